// File: doc/BRIEF.md
# Fence-Gated Allocator with Reorder Buffer

This block sits at the boundary between an in-order uop queue and the out-of-order back end of a small core. Each cycle it looks at up to four uops at the front of the queue. It writes the leading run of non-fence uops into consecutive reorder-buffer slots as one group. Uops that need an execution unit are also pushed to the scheduler. The scheduler is tracked with a credit counter. Completion reports mark reorder-buffer entries done. A limited number of finished entries leave from the head each cycle, strictly in program order.

A fence at the head of the queue serializes the machine. Nothing younger is allocated until every older uop has retired. The fence itself is consumed one cycle after the buffer has been seen empty, which models the restart delay of the rename stage. Groups are issued all-or-nothing. A group waits whole when the scheduler has fewer than four free credits, or when the reorder buffer cannot take the whole group. Two counters record cycles lost to a full scheduler and cycles lost behind a fence.

Top module: `fence_alloc_rob`

## Requirements
- R1: The group is the run of valid slots from slot 0 up to, but not including, the first fence; at most LANES (4) uops. When the group is allocated, `uq_take` equals its size in the same cycle. Lane k receives the slot at (head + occupancy + k) mod ROB_DEPTH.
- R2: While the head slot is not a fence, a non-empty group is refused if the credit count is below LANES. In that case `uq_take` is 0 and `stall_sched` is 1.
- R3: With enough credits, a group is refused when the free slots of the reorder buffer (ROB_DEPTH minus occupancy) are fewer than the group size. In that case `uq_take` is 0 and `stall_rob` is 1.
- R4: When slot 0 holds a fence (kind 4), only the fence can be taken, and nothing is pushed to the scheduler. The fence is consumed (`uq_take` = 1) only in a cycle where the buffer is empty and was also empty in the previous cycle. Otherwise `stall_fence` is 1.
- R5: A fence in slot 1 to 3 cuts the group to the slots in front of it.
- R6: Kinds 0 (ALU), 1 (multiply) and 2 (branch) need execution. For these, `sch_push` is set and the entry is written not-done. Kind 3, and the unused kinds 5 to 7, enter the buffer already done and are never pushed.
- R7: `cmp_valid` marks entry `cmp_tag` done at the next edge. `ret_count` is the number of consecutive done entries from the head, capped at RET_MAX. Those entries leave at the edge.
- R8: The credit count starts at SCHED_DEPTH. At each edge it drops by the number of pushes and rises by `sch_credit_ret`.
- R9: `sched_stall_cycles` and `fence_stall_cycles` count the edges at which `stall_sched` and `stall_fence` were high. The two stall flags are never high together.
- R10: After reset the buffer is empty, the credits are full, both counters are zero and a fence may pass at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uq_valid | input | LANES | Valid slots at the queue front (contiguous from slot 0) |
| uq_kind | input | 3*LANES | 3-bit kind per slot |
| uq_take | output | clog2(LANES+1) | Slots consumed this cycle |
| sch_push | output | LANES | Per-lane push to the scheduler |
| sch_tag | output | LANES*clog2(ROB_DEPTH) | Reorder-buffer index per lane |
| sch_credit_ret | input | clog2(LANES+1) | Scheduler credits returned this cycle |
| cmp_valid | input | 1 | Completion report valid |
| cmp_tag | input | clog2(ROB_DEPTH) | Entry that completed |
| ret_count | output | clog2(RET_MAX+1) | Entries retiring this cycle |
| stall_sched | output | 1 | Group held for lack of credits |
| stall_fence | output | 1 | Fence waiting for drain |
| stall_rob | output | 1 | Group held for lack of buffer slots |
| sched_stall_cycles | output | CNT_W | Count of scheduler-stall cycles |
| fence_stall_cycles | output | CNT_W | Count of fence-stall cycles |

## Verification
`uq_take`, `sch_push`, `sch_tag`, `ret_count` and the three stall flags are combinational and are due in the same cycle as the queue contents that cause them. Allocation, completion and retirement change the buffer state at the next rising edge. Each stall counter moves one edge after its flag. A fence is released no earlier than two edges after the edge that retires the last older entry.

The bench drives inputs at the falling edge and samples 1 ns later. A behavioural model, built from queues and integers, predicts every output for that cycle before the model state advances. The counters are compared at that same point, so they already include every earlier edge.

// File: rtl/fence_alloc_rob.sv
module fence_alloc_rob #(
  parameter int LANES       = 4,
  parameter int ROB_DEPTH   = 16,
  parameter int SCHED_DEPTH = 8,
  parameter int RET_MAX     = 4,
  parameter int CNT_W       = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [LANES-1:0]                     uq_valid,
  input  logic [3*LANES-1:0]                   uq_kind,
  output logic [$clog2(LANES+1)-1:0]           uq_take,
  output logic [LANES-1:0]                     sch_push,
  output logic [LANES*$clog2(ROB_DEPTH)-1:0]   sch_tag,
  input  logic [$clog2(LANES+1)-1:0]           sch_credit_ret,
  input  logic                                 cmp_valid,
  input  logic [$clog2(ROB_DEPTH)-1:0]         cmp_tag,
  output logic [$clog2(RET_MAX+1)-1:0]         ret_count,
  output logic                                 stall_sched,
  output logic                                 stall_fence,
  output logic                                 stall_rob,
  output logic [CNT_W-1:0]                     sched_stall_cycles,
  output logic [CNT_W-1:0]                     fence_stall_cycles
);
  localparam int IW = $clog2(ROB_DEPTH);
  localparam int CW = $clog2(SCHED_DEPTH+1);
  localparam int TW = $clog2(LANES+1);
  localparam logic [2:0] K_FENCE = 3'd4;

  logic [IW-1:0]        head, tail;
  logic [IW:0]          count;
  logic [ROB_DEPTH-1:0] done;
  logic [CW-1:0]        credits;
  logic                 armed;
  logic [TW-1:0]        grp;
  logic [LANES-1:0]     exec_k;
  logic                 head_fence, fence_go, alloc;

  assign tail       = head + count[IW-1:0];
  assign head_fence = uq_valid[0] && (uq_kind[2:0] == K_FENCE);
  assign fence_go   = head_fence && (count == '0) && armed;

  always_comb begin
    logic run;
    run = 1'b1;
    grp = '0;
    for (int k = 0; k < LANES; k++) begin
      exec_k[k] = uq_kind[3*k +: 3] < 3'd3;
      if (run && uq_valid[k] && (uq_kind[3*k +: 3] != K_FENCE)) grp = grp + TW'(1);
      else run = 1'b0;
    end
  end

  always_comb begin
    logic run;
    run = 1'b1;
    ret_count = '0;
    for (int i = 0; i < RET_MAX; i++) begin
      if (run && ((IW+1)'(i) < count) && done[head + IW'(i)])
        ret_count = ret_count + $bits(ret_count)'(1);
      else run = 1'b0;
    end
  end

  assign stall_fence = head_fence && !fence_go;
  assign stall_sched = !head_fence && (grp != '0) && (credits < CW'(LANES));
  assign stall_rob   = !head_fence && (grp != '0) && !stall_sched &&
                       (((IW+1)'(ROB_DEPTH) - count) < (IW+1)'(grp));
  assign alloc       = !head_fence && (grp != '0) && !stall_sched && !stall_rob;
  assign uq_take     = fence_go ? TW'(1) : (alloc ? grp : '0);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sch_push[k]           = alloc && (TW'(k) < grp) && exec_k[k];
    assign sch_tag[k*IW +: IW]   = tail + IW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head               <= '0;
      count              <= '0;
      done               <= '0;
      credits            <= CW'(SCHED_DEPTH);
      armed              <= 1'b1;
      sched_stall_cycles <= '0;
      fence_stall_cycles <= '0;
    end else begin
      head    <= head + IW'(ret_count);
      count   <= count + (alloc ? (IW+1)'(grp) : '0) - (IW+1)'(ret_count);
      credits <= credits - CW'($countones(sch_push)) + CW'(sch_credit_ret);
      armed   <= (count == '0);
      if (stall_sched) sched_stall_cycles <= sched_stall_cycles + CNT_W'(1);
      if (stall_fence) fence_stall_cycles <= fence_stall_cycles + CNT_W'(1);
      if (cmp_valid) done[cmp_tag] <= 1'b1;
      for (int k = 0; k < LANES; k++)
        if (alloc && (TW'(k) < grp)) done[tail + IW'(k)] <= !exec_k[k];
    end
  end
endmodule

// File: rtl/fence_alloc_rob_chk.sv
module fence_alloc_rob_chk #(
  parameter int LANES       = 4,
  parameter int ROB_DEPTH   = 16,
  parameter int SCHED_DEPTH = 8,
  parameter int RET_MAX     = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [LANES-1:0]                  uq_valid,
  input logic [3*LANES-1:0]                uq_kind,
  input logic [$clog2(LANES+1)-1:0]        uq_take,
  input logic [LANES-1:0]                  sch_push,
  input logic [$clog2(RET_MAX+1)-1:0]      ret_count,
  input logic                              stall_sched,
  input logic                              stall_fence,
  input logic [$clog2(ROB_DEPTH):0]        count,
  input logic [$clog2(SCHED_DEPTH+1)-1:0]  credits
);
  logic [LANES-1:0] needs_unit;
  logic             fence_front;

  always_comb
    for (int k = 0; k < LANES; k++) needs_unit[k] = uq_kind[3*k +: 3] < 3'd3;
  assign fence_front = uq_valid[0] && (uq_kind[2:0] == 3'd4);

  AST_TAKE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) uq_take <= LANES); // R1
  AST_FULL_CREDITS: assert property (@(posedge clk) disable iff (!rst_n) (sch_push != '0) |-> credits >= LANES); // R2
  AST_ROB_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= ROB_DEPTH); // R3
  AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n) (fence_front && uq_take != '0) |-> (count == '0 && $past(count) == '0)); // R4
  AST_FENCE_ALONE: assert property (@(posedge clk) disable iff (!rst_n) fence_front |-> (sch_push == '0 && uq_take <= 1)); // R4
  AST_PUSH_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (sch_push & ~needs_unit) == '0); // R6
  AST_RETIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n) ret_count <= count); // R7
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) credits <= SCHED_DEPTH); // R8
  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(stall_sched && stall_fence)); // R9
endmodule

bind fence_alloc_rob fence_alloc_rob_chk #(
  .LANES(LANES), .ROB_DEPTH(ROB_DEPTH), .SCHED_DEPTH(SCHED_DEPTH), .RET_MAX(RET_MAX)
) u_chk (.*);

// File: tb/fence_alloc_rob_bench.sv
`timescale 1ns/1ps
module fence_alloc_rob_bench;
  localparam int L = 4, D = 16, S = 8, R = 4, IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [L-1:0] uq_valid;
  logic [3*L-1:0] uq_kind;
  logic [2:0] uq_take;
  logic [L-1:0] sch_push;
  logic [L*IW-1:0] sch_tag;
  logic [2:0] sch_credit_ret;
  logic cmp_valid;
  logic [IW-1:0] cmp_tag;
  logic [2:0] ret_count;
  logic stall_sched, stall_fence, stall_rob;
  logic [15:0] sched_stall_cycles, fence_stall_cycles;

  fence_alloc_rob u_fence_alloc_rob (.*);

  int checks = 0, fails = 0, cyc = 0;
  int m_head = 0, m_cnt = 0, m_cred = S, m_armed = 1, m_sc = 0, m_fc = 0;
  bit m_done[D];
  int prog[$], pend_tag[$], pend_rdy[$];
  int seen_take = 0, seen_rob = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int lat(int kind);
    return (kind == 1) ? 6 : (kind == 2) ? 2 : 1;
  endfunction

  task automatic step();
    int nret, grp, take, hf, go, ss, sf, sr, ci, nexec, tg;
    bit run;
    @(negedge clk);
    for (int k = 0; k < L; k++) begin
      uq_valid[k] = k < prog.size();
      uq_kind[3*k +: 3] = (k < prog.size()) ? 3'(prog[k]) : 3'd0;
    end
    ci = -1;
    for (int i = 0; i < pend_tag.size(); i++) if (ci < 0 && pend_rdy[i] <= cyc) ci = i;
    cmp_valid = ci >= 0;
    cmp_tag = (ci >= 0) ? IW'(pend_tag[ci]) : '0;
    sch_credit_ret = (ci >= 0) ? 3'd1 : 3'd0;
    #1;
    nret = 0; run = 1;
    for (int i = 0; i < R; i++)
      if (run && i < m_cnt && m_done[(m_head + i) % D]) nret++; else run = 0;
    hf = (prog.size() > 0 && prog[0] == 4);
    grp = 0; run = 1;
    for (int k = 0; k < L; k++)
      if (run && k < prog.size() && prog[k] != 4) grp++; else run = 0;
    go = hf && m_cnt == 0 && m_armed;
    sf = hf && !go;
    ss = !hf && grp > 0 && m_cred < L;
    sr = !hf && grp > 0 && !ss && (D - m_cnt) < grp;
    take = go ? 1 : (!hf && grp > 0 && !ss && !sr) ? grp : 0;
    seen_take = uq_take;
    if (stall_rob) seen_rob = 1;
    chk("R1", "uq_take", uq_take, take);
    nexec = 0;
    for (int k = 0; k < L; k++) begin
      int ex;
      ex = (!hf && k < take && prog[k] < 3);
      nexec += ex;
      chk("R6", "sch_push", sch_push[k], ex);
      if (ex) chk("R1", "sch_tag", sch_tag[k*IW +: IW], (m_head + m_cnt + k) % D);
    end
    chk("R7", "ret_count", ret_count, nret);
    chk("R2", "stall_sched", stall_sched, ss);
    chk("R3", "stall_rob", stall_rob, sr);
    chk("R4", "stall_fence", stall_fence, sf);
    chk("R9", "sched_stall_cycles", sched_stall_cycles, m_sc);
    chk("R9", "fence_stall_cycles", fence_stall_cycles, m_fc);
    chk("R9", "stall exclusive", stall_sched & stall_fence, 0);
    if (ci >= 0) begin
      m_done[pend_tag[ci]] = 1;
      pend_tag.delete(ci);
      pend_rdy.delete(ci);
    end
    if (!hf) for (int k = 0; k < take; k++) begin
      tg = (m_head + m_cnt + k) % D;
      m_done[tg] = prog[k] >= 3;
      if (prog[k] < 3) begin pend_tag.push_back(tg); pend_rdy.push_back(cyc + lat(prog[k])); end
    end
    m_armed = (m_cnt == 0);
    m_head = (m_head + nret) % D;
    m_cnt += (hf ? 0 : take) - nret;
    m_cred += ((ci >= 0) ? 1 : 0) - nexec;
    m_sc += ss;
    m_fc += sf;
    for (int k = 0; k < take; k++) void'(prog.pop_front());
    cyc++;
  endtask

  task automatic drain();
    int n = 0;
    while ((prog.size() > 0 || m_cnt > 0 || pend_tag.size() > 0) && n < 3000) begin step(); n++; end
    step();
    step();
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done cycle=%0d", cyc, cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; uq_valid = '0; uq_kind = '0; sch_credit_ret = '0; cmp_valid = 0; cmp_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10", "take after reset", uq_take, 0);
    chk("R10", "sched counter after reset", sched_stall_cycles, 0);
    chk("R10", "fence counter after reset", fence_stall_cycles, 0);
    chk("R10", "retire after reset", ret_count, 0);
    prog = {4, 0, 0, 0};
    step();
    chk("R10", "fence passes at once after reset", seen_take, 1);
    drain();

    for (int i = 0; i < 40; i++)
      prog.push_back((i % 4 == 3) ? 3 : (i % 5 == 0) ? 1 : (i % 3 == 0) ? 2 : (i % 7 == 6) ? 6 : 0);
    drain();

    base = sched_stall_cycles;
    for (int i = 0; i < 24; i++) prog.push_back(1);
    drain();
    chk("R8", "credit exhaustion stalled", int'(sched_stall_cycles) > base, 1);

    seen_rob = 0;
    prog.push_back(1);
    for (int i = 0; i < 24; i++) prog.push_back((i % 5 == 4) ? 5 : 3);
    drain();
    chk("R3", "buffer-full stall seen", seen_rob, 1);

    base = fence_stall_cycles;
    prog = {0, 3, 4, 0, 1, 4, 4, 2, 3, 0, 1, 4, 0, 0, 0, 0, 4, 1, 1, 1, 2, 4, 3};
    step();
    chk("R5", "fence in slot 2 cuts group", seen_take, 2);
    drain();
    chk("R4", "fence waits counted", int'(fence_stall_cycles) > base, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule